// File: doc/BRIEF.md
# Multi-Format Panel Video Timing Generator

This block generates the raster timing for a small display panel. It runs on the pixel clock. A horizontal pixel counter and a vertical line counter step through a timing set that a 4-bit format code selects. From the counter position the block produces horizontal sync, vertical sync, a data-enable strobe and the coordinates of the current active pixel. The data path, scaling and colour handling sit outside the block. A display controller drives pixels using the strobes and coordinates.

Each sync output and the data-enable output has its own polarity input. A 2-bit sync-mode input selects which of the strobes are driven. The strobes that are not selected rest at their inactive level.

The format code is sampled only when the raster wraps back to its first pixel, so a running frame always completes with one set of numbers. A code that has no timing set stops the raster and raises an error flag. While the raster is stopped the block samples the code on every cycle, so a valid code starts a new frame at once.

Top module: `panel_timing_gen`

## Requirements
- R1: While reset is asserted and directly after it, every strobe sits at its inactive level, the error flag is low and both coordinates are zero. The first frame after reset starts at pixel 0 of line 0.
- R2: Horizontal timing in pixels is active/front/sync/back, sized by the format code as follows. Code 2: 320/359/1/241. Code 3: 360/35/1/241. Codes 5 and 6: 320/38/1/50. Code 7: 640/252/1/28. Code 8: 720/252/1/24. Code 10: 720/3/1/272. Code 11: 640/3/1/272.
- R3: Vertical timing in lines is active/front/sync/back, sized by the format code as follows. Code 2: 240/4/1/17. Code 3: 240/21/1/0. Codes 5 and 6: 240/4/1/17. Code 7: 320/4/1/18. Code 8: 360/4/1/18. Codes 10 and 11: 480/4/1/15.
- R4: Each line runs active, then front porch, then sync, then back porch. Frames use the same order in lines. Horizontal sync lasts one clock. Vertical sync lasts one whole line.
- R5: A change on the format input takes effect only at the first pixel of the next frame. The frame in progress keeps its old timing.
- R6: Codes 0, 1, 4, 9 and 12 to 15 are unsupported. With one of them selected, the error flag is high, all strobes are inactive and the coordinates stay at zero. A supported code applied while the raster is stopped starts a frame on the next clock.
- R7: Each polarity input set to 1 makes its strobe active high. Set to 0, the strobe is active low.
- R8: Sync mode 0 drives the syncs only. Mode 1 drives the syncs and data enable. Mode 2 drives data enable only. Mode 3 drives none of them.
- R9: Inside the active area, the x output equals the pixel index within the line and the y output equals the active line index. Outside the active area both are zero. This holds in every sync mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fmt_i | input | 4 | Input-format code that selects the timing set |
| sync_mode_i | input | 2 | Selects which strobes are driven |
| hs_pol_i | input | 1 | Horizontal sync polarity, 1 = active high |
| vs_pol_i | input | 1 | Vertical sync polarity, 1 = active high |
| de_pol_i | input | 1 | Data-enable polarity, 1 = active high |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| px_x_o | output | 10 | Active pixel column, zero outside the active area |
| px_y_o | output | 9 | Active line, zero outside the active area |
| fmt_err_o | output | 1 | Selected format code has no timing set |

## Verification
A wrong counter limit or a wrong table entry changes the sync period, the active width or the porch gap. That shows on the first line for horizontal numbers and within one frame for vertical ones. A format register that loads at the wrong moment changes the line period in the middle of a frame, and this is caught by timing the old frame's wrap point. Wrong gating or a wrong polarity shows at once on the idle level of a strobe. The coordinate outputs reveal a counter that started from the wrong value on the first active pixel after reset.

// File: rtl/panel_timing_pkg.sv
package panel_timing_pkg;
  parameter int HCW = 10;
  parameter int VCW = 9;
  parameter int FCW = 4;

  typedef struct packed {
    logic           ok;
    logic [HCW-1:0] h_act;
    logic [HCW-1:0] h_fp;
    logic [HCW-1:0] h_sw;
    logic [HCW-1:0] h_bp;
    logic [VCW-1:0] v_act;
    logic [VCW-1:0] v_fp;
    logic [VCW-1:0] v_sw;
    logic [VCW-1:0] v_bp;
  } tim_t;
endpackage

// File: rtl/panel_fmt_table.sv
module panel_fmt_table
  import panel_timing_pkg::*;
(
  input  logic [FCW-1:0] code_i,
  output tim_t           tim_o
);
  function automatic tim_t mk(input int ha, input int hf, input int hs, input int hb,
                              input int va, input int vf, input int vs, input int vb);
    tim_t t;
    t.ok    = 1'b1;
    t.h_act = HCW'(ha);
    t.h_fp  = HCW'(hf);
    t.h_sw  = HCW'(hs);
    t.h_bp  = HCW'(hb);
    t.v_act = VCW'(va);
    t.v_fp  = VCW'(vf);
    t.v_sw  = VCW'(vs);
    t.v_bp  = VCW'(vb);
    return t;
  endfunction

  always_comb begin
    tim_o = '0;
    case (code_i)
      FCW'(2):          tim_o = mk(320, 359, 1, 241, 240, 4, 1, 17);
      FCW'(3):          tim_o = mk(360, 35, 1, 241, 240, 21, 1, 0);
      FCW'(5), FCW'(6): tim_o = mk(320, 38, 1, 50, 240, 4, 1, 17);
      FCW'(7):          tim_o = mk(640, 252, 1, 28, 320, 4, 1, 18);
      FCW'(8):          tim_o = mk(720, 252, 1, 24, 360, 4, 1, 18);
      FCW'(10):         tim_o = mk(720, 3, 1, 272, 480, 4, 1, 15);
      FCW'(11):         tim_o = mk(640, 3, 1, 272, 480, 4, 1, 15);
      default:          tim_o = '0;
    endcase
  end
endmodule

// File: rtl/panel_scan_ctr.sv
module panel_scan_ctr
  import panel_timing_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [FCW-1:0] fmt_i,
  output logic [FCW-1:0] fmt_q,
  output logic [HCW-1:0] h_q,
  output logic [VCW-1:0] v_q,
  output logic [HCW-1:0] h_d,
  output logic [VCW-1:0] v_d,
  output tim_t           tim_d
);
  localparam logic [FCW-1:0] FMT_RST = '0;

  tim_t           t_cur;
  tim_t           t_new;
  logic [FCW-1:0] fmt_d;
  logic [HCW-1:0] h_tot;
  logic [VCW-1:0] v_tot;
  logic           line_end;
  logic           frame_end;
  logic           reload;

  panel_fmt_table u_tab_cur (.code_i(fmt_q), .tim_o(t_cur));
  panel_fmt_table u_tab_new (.code_i(fmt_i), .tim_o(t_new));

  always_comb begin
    h_tot     = t_cur.h_act + t_cur.h_fp + t_cur.h_sw + t_cur.h_bp;
    v_tot     = t_cur.v_act + t_cur.v_fp + t_cur.v_sw + t_cur.v_bp;
    line_end  = (h_q == h_tot - HCW'(1));
    frame_end = t_cur.ok && line_end && (v_q == v_tot - VCW'(1));
    reload    = !t_cur.ok || frame_end;
    if (reload) begin
      fmt_d = fmt_i;
      tim_d = t_new;
      h_d   = '0;
      v_d   = '0;
    end else begin
      fmt_d = fmt_q;
      tim_d = t_cur;
      if (line_end) begin
        h_d = '0;
        v_d = v_q + VCW'(1);
      end else begin
        h_d = h_q + HCW'(1);
        v_d = v_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q <= FMT_RST;
      h_q   <= '0;
      v_q   <= '0;
    end else begin
      fmt_q <= fmt_d;
      h_q   <= h_d;
      v_q   <= v_d;
    end
  end
endmodule

// File: rtl/panel_sync_out.sv
module panel_sync_out
  import panel_timing_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [HCW-1:0] h_d,
  input  logic [VCW-1:0] v_d,
  input  tim_t           tim_d,
  input  logic [1:0]     sync_mode_i,
  input  logic           hs_pol_i,
  input  logic           vs_pol_i,
  input  logic           de_pol_i,
  output logic           hs_raw,
  output logic           vs_raw,
  output logic           de_raw,
  output logic           hsync_o,
  output logic           vsync_o,
  output logic           de_o,
  output logic [HCW-1:0] px_x_o,
  output logic [VCW-1:0] px_y_o,
  output logic           fmt_err_o
);
  logic [HCW-1:0] hs_beg, hs_end;
  logic [VCW-1:0] vs_beg, vs_end;
  logic           de_n, hs_n, vs_n, err_n;
  logic [HCW-1:0] x_n;
  logic [VCW-1:0] y_n;
  logic           emit_sync, emit_de;

  always_comb begin
    hs_beg = tim_d.h_act + tim_d.h_fp;
    hs_end = hs_beg + tim_d.h_sw;
    vs_beg = tim_d.v_act + tim_d.v_fp;
    vs_end = vs_beg + tim_d.v_sw;
    de_n   = tim_d.ok && (h_d < tim_d.h_act) && (v_d < tim_d.v_act);
    hs_n   = tim_d.ok && (h_d >= hs_beg) && (h_d < hs_end);
    vs_n   = tim_d.ok && (v_d >= vs_beg) && (v_d < vs_end);
    err_n  = !tim_d.ok;
    x_n    = de_n ? h_d : '0;
    y_n    = de_n ? v_d : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_raw    <= 1'b0;
      vs_raw    <= 1'b0;
      de_raw    <= 1'b0;
      px_x_o    <= '0;
      px_y_o    <= '0;
      fmt_err_o <= 1'b0;
    end else begin
      hs_raw    <= hs_n;
      vs_raw    <= vs_n;
      de_raw    <= de_n;
      px_x_o    <= x_n;
      px_y_o    <= y_n;
      fmt_err_o <= err_n;
    end
  end

  // Mode 0: syncs, 1: syncs+DE, 2: DE only, 3: none.
  always_comb begin
    emit_sync = !sync_mode_i[1];
    emit_de   = sync_mode_i[1] ^ sync_mode_i[0];
    hsync_o   = (hs_raw & emit_sync) ~^ hs_pol_i;
    vsync_o   = (vs_raw & emit_sync) ~^ vs_pol_i;
    de_o      = (de_raw & emit_de) ~^ de_pol_i;
  end
endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen
  import panel_timing_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [3:0]     fmt_i,
  input  logic [1:0]     sync_mode_i,
  input  logic           hs_pol_i,
  input  logic           vs_pol_i,
  input  logic           de_pol_i,
  output logic           hsync_o,
  output logic           vsync_o,
  output logic           de_o,
  output logic [9:0]     px_x_o,
  output logic [8:0]     px_y_o,
  output logic           fmt_err_o
);
  logic           rst_meta, rst_sync_n;
  logic [FCW-1:0] cur_fmt;
  logic [HCW-1:0] h_cnt, h_nxt;
  logic [VCW-1:0] v_cnt, v_nxt;
  tim_t           tim_nxt;
  logic           hs_raw, vs_raw, de_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  panel_scan_ctr u_ctr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .fmt_i (fmt_i),
    .fmt_q (cur_fmt),
    .h_q   (h_cnt),
    .v_q   (v_cnt),
    .h_d   (h_nxt),
    .v_d   (v_nxt),
    .tim_d (tim_nxt)
  );

  panel_sync_out u_out (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .h_d         (h_nxt),
    .v_d         (v_nxt),
    .tim_d       (tim_nxt),
    .sync_mode_i (sync_mode_i),
    .hs_pol_i    (hs_pol_i),
    .vs_pol_i    (vs_pol_i),
    .de_pol_i    (de_pol_i),
    .hs_raw      (hs_raw),
    .vs_raw      (vs_raw),
    .de_raw      (de_raw),
    .hsync_o     (hsync_o),
    .vsync_o     (vsync_o),
    .de_o        (de_o),
    .px_x_o      (px_x_o),
    .px_y_o      (px_y_o),
    .fmt_err_o   (fmt_err_o)
  );
endmodule

// File: rtl/panel_timing_chk.sv
module panel_timing_chk (
  input logic       clk,
  input logic       rst_sync_n,
  input logic [3:0] cur_fmt,
  input logic [9:0] h_cnt,
  input logic [8:0] v_cnt,
  input logic       hs_raw,
  input logic       de_raw,
  input logic [1:0] sync_mode_i,
  input logic       hs_pol_i,
  input logic       vs_pol_i,
  input logic       de_pol_i,
  input logic       hsync_o,
  input logic       vsync_o,
  input logic       de_o,
  input logic [9:0] px_x_o,
  input logic [8:0] px_y_o,
  input logic       fmt_err_o
);
  a_r5_fmt_at_frame_start: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(cur_fmt) |-> (h_cnt == '0 && v_cnt == '0));

  a_r6_err_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fmt_err_o |-> (hsync_o == !hs_pol_i && vsync_o == !vs_pol_i && de_o == !de_pol_i));

  a_r4_hsync_one_clk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hs_raw |=> !hs_raw);

  a_r9_xy_zero_outside: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !de_raw |-> (px_x_o == '0 && px_y_o == '0));

  a_r9_x_steps: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (de_raw && $past(de_raw)) |-> (px_x_o == 10'($past(px_x_o) + 10'd1)));

  a_r8_mode_none: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sync_mode_i == 2'd3) |-> (hsync_o == !hs_pol_i && vsync_o == !vs_pol_i && de_o == !de_pol_i));
endmodule

bind panel_timing_gen panel_timing_chk u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .cur_fmt     (cur_fmt),
  .h_cnt       (h_cnt),
  .v_cnt       (v_cnt),
  .hs_raw      (hs_raw),
  .de_raw      (de_raw),
  .sync_mode_i (sync_mode_i),
  .hs_pol_i    (hs_pol_i),
  .vs_pol_i    (vs_pol_i),
  .de_pol_i    (de_pol_i),
  .hsync_o     (hsync_o),
  .vsync_o     (vsync_o),
  .de_o        (de_o),
  .px_x_o      (px_x_o),
  .px_y_o      (px_y_o),
  .fmt_err_o   (fmt_err_o)
);

// File: tb/panel_timing_gen_bench.sv
module panel_timing_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] fmt;
  logic [1:0] mode;
  logic       hp, vp, dp;
  logic       hsync_o, vsync_o, de_o, fmt_err_o;
  logic [9:0] px_x_o;
  logic [8:0] px_y_o;
  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  panel_timing_gen u_panel_timing_gen (
    .clk(clk), .rst_n(rst_n), .fmt_i(fmt), .sync_mode_i(mode),
    .hs_pol_i(hp), .vs_pol_i(vp), .de_pol_i(dp),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .px_x_o(px_x_o), .px_y_o(px_y_o), .fmt_err_o(fmt_err_o)
  );

  task automatic ceq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start(input logic [3:0] f, input logic [1:0] m, input logic pol);
    rst_n = 1'b0; fmt = f; mode = m; hp = pol; vp = pol; dp = pol;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // R1, R7: reset levels with low-active polarity, first active pixel at (0,0)
  task automatic t_reset_polarity();
    int n;
    rst_n = 1'b0; fmt = 4'd5; mode = 2'd1; hp = 0; vp = 0; dp = 0;
    repeat (3) @(negedge clk);
    ceq("R1 reset levels hs/vs/de (low-active)", {hsync_o, vsync_o, de_o}, 3'b111);
    ceq("R1 reset err", fmt_err_o, 0);
    ceq("R1 reset xy", px_x_o + px_y_o, 0);
    rst_n = 1'b1;
    while (de_o) @(negedge clk);
    ceq("R1 first pixel x", px_x_o, 0);
    ceq("R1 first line y", px_y_o, 0);
    ceq("R7 hsync idle high when pol=0", hsync_o, 1);
    n = 0;
    while (!de_o) begin n++; @(negedge clk); end
    ceq("R7 active-low DE width", n, 320);
    while (hsync_o) @(negedge clk);
    n = 0;
    while (!hsync_o) begin n++; @(negedge clk); end
    ceq("R7 active-low hsync width", n, 1);
  endtask

  // R2, R4, R9: one line of a format
  task automatic t_line(input logic [3:0] f, input int ht, input int ha, input int hf, input bit do_reset);
    int n, g, w, p, lx;
    if (do_reset) start(f, 2'd1, 1'b1);
    while (de_o) @(negedge clk);
    while (!de_o) @(negedge clk);
    ceq($sformatf("R9 fmt%0d x at line start", f), px_x_o, 0);
    n = 0; lx = 0;
    while (de_o) begin n++; lx = px_x_o; @(negedge clk); end
    ceq($sformatf("R2 fmt%0d active width", f), n, ha);
    ceq($sformatf("R9 fmt%0d last x", f), lx, ha - 1);
    g = 0;
    while (!hsync_o) begin g++; @(negedge clk); end
    ceq($sformatf("R4 fmt%0d front porch", f), g, hf);
    w = 0;
    while (hsync_o) begin w++; @(negedge clk); end
    ceq($sformatf("R4 fmt%0d hsync width", f), w, 1);
    p = w;
    while (!hsync_o) begin p++; @(negedge clk); end
    ceq($sformatf("R2 fmt%0d line period", f), p, ht);
  endtask

  // R3, R5, R9: full frame of code 5, switch to code 3 mid-frame
  task automatic t_frame_switch();
    int t0, tv, lines, n, g;
    bit pde, pvs, vs_done, done;
    start(4'd5, 2'd1, 1'b1);
    pde = 0; pvs = 0; vs_done = 0; done = 0; lines = 0; t0 = 0; tv = 0;
    while (!done) begin
      @(negedge clk);
      if (de_o && !pde) begin
        lines++;
        if (lines == 1) t0 = cyc;
        if (lines == 100) ceq("R9 y on active line 99", px_y_o, 99);
        if (lines == 11) fmt = 4'd3;
        if (vs_done) begin
          ceq("R5 old frame kept to its end (R3 total 262 lines)", cyc - t0, 262 * 409);
          done = 1;
        end
      end
      if (vsync_o && !pvs) begin
        ceq("R3 active lines before vsync", lines, 240);
        ceq("R3 vsync start", cyc - t0, 244 * 409);
        tv = cyc;
      end
      if (!vsync_o && pvs) begin
        ceq("R4 vsync lasts one line", cyc - tv, 409);
        vs_done = 1;
      end
      pde = de_o; pvs = vsync_o;
    end
    n = 0;
    while (de_o) begin n++; @(negedge clk); end
    ceq("R5 new format width after wrap", n, 360);
    g = 0;
    while (!hsync_o) begin g++; @(negedge clk); end
    ceq("R5 new format front porch", g, 35);
  endtask

  // R6: unsupported codes, then a supported code starts immediately
  task automatic t_invalid();
    int bad[6] = '{0, 1, 4, 9, 12, 15};
    foreach (bad[i]) begin
      bit quiet;
      start(4'(bad[i]), 2'd1, 1'b1);
      repeat (5) @(negedge clk);
      ceq($sformatf("R6 err for code %0d", bad[i]), fmt_err_o, 1);
      quiet = 1;
      repeat (300) begin
        @(negedge clk);
        if (de_o || hsync_o || vsync_o || px_x_o != 0 || px_y_o != 0) quiet = 0;
      end
      ceq($sformatf("R6 outputs quiet for code %0d", bad[i]), quiet, 1);
    end
    fmt = 4'd7;
    repeat (2) @(negedge clk);
    ceq("R6 err clears on valid code", fmt_err_o, 0);
    ceq("R6 frame starts at once", de_o, 1);
    t_line(4'd7, 921, 640, 252, 0);
  endtask

  // R8: sync modes
  task automatic t_modes();
    for (int m = 0; m < 4; m++) begin
      bit sde, shs;
      int mx;
      start(4'd5, 2'(m), 1'b1);
      sde = 0; shs = 0; mx = 0;
      repeat (1000) begin
        @(negedge clk);
        if (de_o) sde = 1;
        if (hsync_o) shs = 1;
        if (px_x_o > mx) mx = px_x_o;
      end
      ceq($sformatf("R8 mode %0d DE driven", m), sde, (m == 1 || m == 2) ? 1 : 0);
      ceq($sformatf("R8 mode %0d hsync driven", m), shs, (m < 2) ? 1 : 0);
      ceq($sformatf("R9 mode %0d x range", m), mx, 319);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    report();
    $finish;
  end

  initial begin
    t_reset_polarity();
    t_line(4'd2, 921, 320, 359, 1);
    t_line(4'd3, 637, 360, 35, 1);
    t_line(4'd6, 409, 320, 38, 1);
    t_line(4'd8, 997, 720, 252, 1);
    t_line(4'd10, 996, 720, 3, 1);
    t_line(4'd11, 916, 640, 3, 1);
    t_invalid();
    t_modes();
    t_frame_switch();
    report();
    $finish;
  end
endmodule